// File: doc/BRIEF.md
# Configurable Sinc Decimation Filter

This block turns the one-bit pulse-density stream of an external delta-sigma modulator into signed multi-bit conversion results. Each accepted bit is mapped to +1 or −1 and accumulated by a chain of integrators at the bit rate. Every R accepted bits, the selected integrator is sampled into a chain of differentiators running at the reduced rate. The number of active stages (the filter order, one to three) and the ratio R (4 to 256) are configuration inputs.

The modulator clock arrives as a level, synchronous to the core clock. A bit is taken on its rising or falling edge, as chosen, but only while the run enable is high. An initialization input, active on a selectable edge, restarts the filter. A restart clears every integrator, differentiator, the ratio counter and the settling count, and loads the order, ratio and alignment settings. The same load happens on the first clock after reset. Each finished, settled conversion raises a one-cycle update strobe alongside the result word.

Top module: `sinc_decim`

## Requirements
- R1: While reset is asserted, `result_o` is 0 and `update_o` and `settled_o` are low.
- R2: A bit is accepted only when the selected edge of `mclk_i` is seen (`mclk_fall_i`=0 selects low-to-high, 1 selects high-to-low) while `run_i` is high. The value of `bit_i` at any other edge or cycle has no effect on any later result.
- R3: One conversion completes for every R accepted bits. R is `ratio_i` limited to the range 4 to 256: a value below 4 acts as 4 and a value above 256 acts as 256.
- R4: With `bit_i`=1 counted as +1 and 0 as −1, and with zero filter state at restart, conversion m (m = 1, 2, …) equals the input convolved k times with a length-R box, taken at accepted bit index mR−1, where k is the order. The result is exact up to full scale ±R^k.
- R5: After a restart, the first k conversions of an order-k filter produce no strobe. `settled_o` rises in the cycle after the k-th conversion and stays high until the next restart. Every later conversion strobes.
- R6: `update_o` is high for exactly one cycle, in the cycle after the clock edge on which the R-th bit of a conversion is accepted, and `result_o` holds that conversion from then on.
- R7: With alignment right (`left_i`=0), `result_o` is the 26-bit result sign-extended to 32 bits. With alignment left (`left_i`=1), it is the result shifted up by 6 bits with zeros below.
- R8: The selected edge of `init_i` (`init_fall_i`=0 rising, 1 falling) restarts the filter. On the next cycle `result_o` is 0 and `update_o` and `settled_o` are low. The opposite edge has no effect.
- R9: The order, ratio and alignment inputs are loaded only at a restart, including the first clock after reset. Changing them at any other time leaves the running conversion unaffected.
- R10: Order code 1 selects first, 2 second and 3 third order, and code 0 acts as first order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Sample enable; bits are accepted only while high |
| mclk_i | input | 1 | Modulator clock level, synchronous to clk_i |
| mclk_fall_i | input | 1 | Sampling edge select: 0 rising, 1 falling |
| bit_i | input | 1 | Modulator bitstream |
| ord_i | input | 2 | Filter order code, loaded at restart |
| ratio_i | input | 9 | Decimation ratio, loaded at restart |
| left_i | input | 1 | Alignment: 0 right, 1 left, loaded at restart |
| init_i | input | 1 | Filter initialization trigger |
| init_fall_i | input | 1 | Trigger edge select: 0 rising, 1 falling |
| result_o | output | 32 | Aligned signed conversion result |
| update_o | output | 1 | One-cycle strobe for a settled conversion |
| settled_o | output | 1 | High once the first k conversions after restart have passed |

## Verification
The assertions assume that `mclk_i` and `init_i` are already synchronous to the core clock. They also assume that the modulator clock holds each level for at least one core cycle, so a sampling edge comes at most every other cycle, and with a ratio of at least 4 two strobes cannot fall in adjacent cycles. The bench drives every input at the falling core-clock edge. It builds each accepted bit from a non-selected edge followed by the selected one, and it inserts bursts of edges with `run_i` low carrying random bits. Configuration inputs change only between whole bench steps, so a new setting either waits for a trigger or is meant to be ignored.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  // Highest filter order supported; each order adds one integrator and one differentiator.
  localparam int unsigned MAX_ORDER = 3;
  localparam int unsigned ORD_W     = 2;

  typedef enum logic {
    ALIGN_RIGHT = 1'b0,
    ALIGN_LEFT  = 1'b1
  } align_e;

  // Order code 0 is folded onto first order.
  function automatic logic [ORD_W-1:0] order_norm(input logic [ORD_W-1:0] code);
    return (code == '0) ? ORD_W'(1) : code;
  endfunction
endpackage

// File: rtl/sinc_edge_det.sv
module sinc_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  input  logic fall_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sig_i;
  end

  always_comb begin
    if (fall_i) pulse_o = prev_q & ~sig_i;
    else        pulse_o = sig_i & ~prev_q;
  end
endmodule

// File: rtl/sinc_integ.sv
module sinc_integ #(
  parameter int unsigned W = 26,
  parameter int unsigned N = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic [W-1:0]        x_i,
  output logic [N-1:0][W-1:0] sum_o
);
  logic [N-1:0][W-1:0] acc_q, acc_d;

  // Stages are chained without pipelining so that every stage already
  // includes the bit accepted in this cycle.
  always_comb begin
    logic [W-1:0] carry;
    carry = x_i;
    for (int j = 0; j < N; j++) begin
      carry    = acc_q[j] + carry;
      sum_o[j] = carry;
    end
  end

  always_comb begin
    acc_d = acc_q;
    if (clr_i)     acc_d = '0;
    else if (en_i) acc_d = sum_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end
endmodule

// File: rtl/sinc_comb.sv
module sinc_comb #(
  parameter int unsigned W = 26,
  parameter int unsigned N = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                en_i,
  input  logic [W-1:0]        d_i,
  output logic [N-1:0][W-1:0] diff_o
);
  logic [N-1:0][W-1:0] dly_q, dly_d;

  always_comb begin
    logic [W-1:0] stage_in;
    stage_in = d_i;
    dly_d    = dly_q;
    for (int j = 0; j < N; j++) begin
      diff_o[j] = stage_in - dly_q[j];
      if (clr_i)     dly_d[j] = '0;
      else if (en_i) dly_d[j] = stage_in;
      stage_in = diff_o[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= '0;
    else         dly_q <= dly_d;
  end
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_pkg::*;
#(
  parameter int unsigned RATIO_W = 9,
  parameter int unsigned OUT_W   = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               run_i,
  input  logic               mclk_i,
  input  logic               mclk_fall_i,
  input  logic               bit_i,
  input  logic [ORD_W-1:0]   ord_i,
  input  logic [RATIO_W-1:0] ratio_i,
  input  logic               left_i,
  input  logic               init_i,
  input  logic               init_fall_i,
  output logic [OUT_W-1:0]   result_o,
  output logic               update_o,
  output logic               settled_o
);
  // Full scale is R^order with R = 2^(RATIO_W-1); one extra bit for the sign.
  localparam int unsigned ACC_W = MAX_ORDER * (RATIO_W - 1) + 2;
  localparam int unsigned PAD_W = OUT_W - ACC_W;   // must be at least 1
  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(4);
  localparam logic [RATIO_W-1:0] MAX_R = RATIO_W'(1 << (RATIO_W - 1));

  logic mclk_evt, init_evt, start_q, restart, samp, dump;

  sinc_edge_det u_mclk_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (mclk_i),
    .fall_i  (mclk_fall_i),
    .pulse_o (mclk_evt)
  );

  sinc_edge_det u_init_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sig_i   (init_i),
    .fall_i  (init_fall_i),
    .pulse_o (init_evt)
  );

  // The first clock after reset acts as a restart so settings are loaded.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) start_q <= 1'b1;
    else         start_q <= 1'b0;
  end

  assign restart = init_evt | start_q;
  assign samp    = run_i & mclk_evt & ~restart;

  // ---------------- configuration held between restarts ----------------
  logic [ORD_W-1:0]   ord_q, ord_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d, ratio_lim;
  align_e             align_q, align_d;

  always_comb begin
    if (ratio_i < MIN_R)      ratio_lim = MIN_R;
    else if (ratio_i > MAX_R) ratio_lim = MAX_R;
    else                      ratio_lim = ratio_i;
  end

  always_comb begin
    ord_d   = ord_q;
    ratio_d = ratio_q;
    align_d = align_q;
    if (restart) begin
      ord_d   = order_norm(ord_i);
      ratio_d = ratio_lim;
      align_d = align_e'(left_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ord_q   <= ORD_W'(MAX_ORDER);
      ratio_q <= MAX_R;
      align_q <= ALIGN_RIGHT;
    end else begin
      ord_q   <= ord_d;
      ratio_q <= ratio_d;
      align_q <= align_d;
    end
  end

  // ---------------- decimation counter ----------------
  logic [RATIO_W-1:0] cnt_q, cnt_d;

  assign dump = samp & (cnt_q == (ratio_q - 1'b1));

  always_comb begin
    cnt_d = cnt_q;
    if (restart)   cnt_d = '0;
    else if (dump) cnt_d = '0;
    else if (samp) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // ---------------- integrator and differentiator chains ----------------
  logic [ACC_W-1:0]                x_val, tap, sel_diff;
  logic [MAX_ORDER-1:0][ACC_W-1:0] integ_sum, comb_diff;

  assign x_val = bit_i ? ACC_W'(1) : '1;   // +1 / -1

  sinc_integ #(.W(ACC_W), .N(MAX_ORDER)) u_integ (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .en_i   (samp),
    .x_i    (x_val),
    .sum_o  (integ_sum)
  );

  always_comb begin
    tap = integ_sum[0];
    for (int j = 0; j < MAX_ORDER; j++)
      if (ORD_W'(j + 1) == ord_q) tap = integ_sum[j];
  end

  sinc_comb #(.W(ACC_W), .N(MAX_ORDER)) u_comb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart),
    .en_i   (dump),
    .d_i    (tap),
    .diff_o (comb_diff)
  );

  always_comb begin
    sel_diff = comb_diff[0];
    for (int j = 0; j < MAX_ORDER; j++)
      if (ORD_W'(j + 1) == ord_q) sel_diff = comb_diff[j];
  end

  // ---------------- result, settling and strobe ----------------
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ORD_W-1:0] scnt_q, scnt_d;
  logic             settled_q, settled_d, upd_q, upd_d;

  always_comb begin
    acc_d     = acc_q;
    scnt_d    = scnt_q;
    settled_d = settled_q;
    upd_d     = 1'b0;
    if (restart) begin
      acc_d     = '0;
      scnt_d    = '0;
      settled_d = 1'b0;
    end else if (dump) begin
      acc_d = sel_diff;
      if (settled_q) begin
        upd_d = 1'b1;
      end else begin
        scnt_d = scnt_q + 1'b1;
        if ((scnt_q + 1'b1) == ord_q) settled_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      scnt_q    <= '0;
      settled_q <= 1'b0;
      upd_q     <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      scnt_q    <= scnt_d;
      settled_q <= settled_d;
      upd_q     <= upd_d;
    end
  end

  always_comb begin
    if (align_q == ALIGN_LEFT) result_o = {acc_q, {PAD_W{1'b0}}};
    else                       result_o = {{PAD_W{acc_q[ACC_W-1]}}, acc_q};
  end

  assign update_o  = upd_q;
  assign settled_o = settled_q;
endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk #(
  parameter int unsigned OUT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             mclk_i,
  input logic             mclk_fall_i,
  input logic             init_i,
  input logic             init_fall_i,
  input logic             update_o,
  input logic             settled_o,
  input logic [OUT_W-1:0] result_o
);
  logic mclk_prev, init_prev, take_bit, trig_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mclk_prev <= 1'b0;
      init_prev <= 1'b0;
    end else begin
      mclk_prev <= mclk_i;
      init_prev <= init_i;
    end
  end

  assign take_bit  = run_i & (mclk_fall_i ? (mclk_prev & ~mclk_i) : (~mclk_prev & mclk_i));
  assign trig_seen = init_fall_i ? (init_prev & ~init_i) : (~init_prev & init_i);

  // R6: strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |=> !update_o);

  // R2: no strobe without an accepted bit in the cycle before
  a_r2_strobe_needs_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_bit |=> !update_o);

  // R5: strobes only once settled
  a_r5_strobe_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> settled_o);

  // R5: settled stays high until a restart
  a_r5_settled_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled_o && !trig_seen) |=> settled_o);

  // R8: trigger clears result and flags
  a_r8_trigger_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_seen |=> (result_o == '0 && !settled_o && !update_o));
endmodule

bind sinc_decim sinc_decim_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .run_i       (run_i),
  .mclk_i      (mclk_i),
  .mclk_fall_i (mclk_fall_i),
  .init_i      (init_i),
  .init_fall_i (init_fall_i),
  .update_o    (update_o),
  .settled_o   (settled_o),
  .result_o    (result_o)
);

// File: tb/sinc_decim_test.sv
`timescale 1ns/1ps
module sinc_decim_test;
  localparam int RATIO_W = 9;
  localparam int OUT_W   = 32;
  localparam int PAD     = 6;

  logic clk, rst_ni, run_i, mclk_i, mclk_fall_i, bit_i, left_i, init_i, init_fall_i;
  logic [1:0]         ord_i;
  logic [RATIO_W-1:0] ratio_i;
  logic [OUT_W-1:0]   result_o;
  logic               update_o, settled_o;

  sinc_decim #(.RATIO_W(RATIO_W), .OUT_W(OUT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .mclk_i(mclk_i),
    .mclk_fall_i(mclk_fall_i), .bit_i(bit_i), .ord_i(ord_i), .ratio_i(ratio_i),
    .left_i(left_i), .init_i(init_i), .init_fall_i(init_fall_i),
    .result_o(result_o), .update_o(update_o), .settled_o(settled_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int     n_vec, n_bad;
  int     samp [0:4095];
  longint za [0:4095];
  longint zb [0:4095];
  int     k_m, r_m, left_m, ns, cnt_m, mo;
  bit     boot, mclk_v, ini_v;

  function automatic int norm_ord(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int clamp_r(input int r);
    if (r < 4) return 4;
    if (r > 256) return 256;
    return r;
  endfunction

  // k-fold box convolution of the +/-1 stream, read at index last
  function automatic longint ref_out(input int k, input int r, input int last);
    for (int i = 0; i <= last; i++) za[i] = longint'(samp[i]);
    for (int s = 0; s < k; s++) begin
      longint acc;
      acc = 0;
      for (int i = 0; i <= last; i++) begin
        acc += za[i];
        if (i >= r) acc -= za[i-r];
        zb[i] = acc;
      end
      for (int i = 0; i <= last; i++) za[i] = zb[i];
    end
    return za[last];
  endfunction

  function automatic logic [31:0] aligned(input longint y, input int lft);
    if (lft != 0) return 32'(y <<< PAD);
    return 32'(y);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One core cycle: drive at falling edge, let one rising edge pass, check.
  task automatic step(input bit m, input bit b, input bit r, input bit ini);
    bit sel_edge, trig_edge;
    mclk_i = m; bit_i = b; run_i = r; init_i = ini;
    sel_edge  = mclk_fall_i ? (mclk_v && !m) : (!mclk_v && m);
    trig_edge = init_fall_i ? (ini_v && !ini) : (!ini_v && ini);
    mclk_v = m; ini_v = ini;
    @(posedge clk);
    @(negedge clk);
    if (boot || trig_edge) begin
      boot = 0;
      k_m = norm_ord(int'(ord_i)); r_m = clamp_r(int'(ratio_i)); left_m = int'(left_i);
      ns = 0; cnt_m = 0; mo = 0;
      check(result_o == '0, "R8", "result after restart", longint'(result_o), 0);
      check(!settled_o && !update_o, "R8", "flags after restart",
            longint'({settled_o, update_o}), 0);
    end else if (r && sel_edge) begin
      samp[ns] = b ? 1 : -1;
      ns++; cnt_m++;
      if (cnt_m == r_m) begin
        cnt_m = 0; mo++;
        if (mo > k_m) begin
          longint y;
          logic [31:0] w;
          y = ref_out(k_m, r_m, ns - 1);
          w = aligned(y, left_m);
          check(update_o, "R6", "strobe after R-th bit", longint'(update_o), 1);
          check(result_o == w, left_m != 0 ? "R7" : "R4", "conversion value",
                longint'($signed(result_o)), longint'($signed(w)));
        end else begin
          check(!update_o, "R5", "strobe before settling", longint'(update_o), 0);
        end
        check(settled_o == (mo >= k_m), "R5", "settled flag",
              longint'(settled_o), longint'(mo >= k_m));
      end else begin
        check(!update_o, "R3", "strobe mid-conversion", longint'(update_o), 0);
      end
    end else begin
      check(!update_o, "R2", "strobe without accepted bit", longint'(update_o), 0);
    end
  endtask

  task automatic one_bit(input bit b);
    bit a;
    a = !mclk_fall_i;
    step(!a, 1'($urandom), 1'b1, ini_v);   // non-selected edge, junk bit
    step(a, b, 1'b1, ini_v);
  endtask

  task automatic idle_burst();
    bit a;
    a = !mclk_fall_i;
    step(!a, 1'($urandom), 1'b0, ini_v);
    step(a, 1'($urandom), 1'b0, ini_v);    // selected edge with run low
  endtask

  task automatic feed(input int mode, input int nouts);
    int tgt;
    tgt = mo + nouts;
    while (mo < tgt) begin
      bit b;
      if ($urandom % 8 == 0) idle_burst();
      b = (mode == 1) ? 1'b1 : (mode == 2) ? 1'b0 : 1'($urandom);
      one_bit(b);
    end
  endtask

  task automatic restart_trig();
    step(mclk_v, 1'b0, 1'b1, 1'b1);
    step(mclk_v, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic scenario(input int o, input int r, input bit lft, input int nouts, input int mode);
    ord_i = 2'(o); ratio_i = RATIO_W'(r); left_i = lft;
    restart_trig();
    feed(mode, nouts);
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    n_vec = 0; n_bad = 0;
    rst_ni = 1'b0; run_i = 1'b0; mclk_i = 1'b0; bit_i = 1'b0; init_i = 1'b0;
    mclk_fall_i = 1'b0; init_fall_i = 1'b0;
    ord_i = 2'd3; ratio_i = RATIO_W'(4); left_i = 1'b0;
    boot = 1; mclk_v = 0; ini_v = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(result_o == '0, "R1", "result in reset", longint'(result_o), 0);
    check(!update_o, "R1", "strobe in reset", longint'(update_o), 0);
    check(!settled_o, "R1", "settled in reset", longint'(settled_o), 0);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, 1'b1, 1'b0);          // R9: settings loaded on first clock

    feed(0, 14);                           // third order, R=4, random
    scenario(2, 16, 1'b1, 10, 0);          // R7 left alignment
    scenario(1, 2, 1'b0, 6, 0);            // R3 ratio below range acts as 4
    scenario(0, 37, 1'b0, 6, 0);           // R10 code 0 is first order
    scenario(3, 256, 1'b0, 5, 1);          // R4 full scale +2^24
    scenario(3, 256, 1'b1, 5, 2);          // R4/R7 full scale negative, left
    scenario(1, 511, 1'b0, 3, 0);          // R3 ratio above range acts as 256

    mclk_fall_i = 1'b1;                    // R2 falling-edge sampling
    scenario(2, 7, 1'b0, 8, 0);

    // restart in the middle of a conversion, falling trigger edge (R8)
    one_bit(1'b1); one_bit(1'b0); one_bit(1'b1);
    init_fall_i = 1'b1;
    scenario(3, 5, 1'b1, 9, 0);

    // R8: opposite edges ignored
    step(mclk_v, 1'b0, 1'b1, 1'b1);        // rising while falling selected
    init_fall_i = 1'b0;
    step(mclk_v, 1'b0, 1'b1, 1'b0);        // falling while rising selected
    feed(0, 4);

    // R9: new settings without a trigger do nothing
    ord_i = 2'd1; ratio_i = RATIO_W'(9); left_i = 1'b0;
    feed(0, 5);
    restart_trig();                        // now they take effect
    feed(0, 6);

    mclk_fall_i = 1'b0;
    scenario(2, 4, 1'b0, 20, 0);
    finish_up();
  end
endmodule